// File: doc/BRIEF.md
# Shared-Bus DRAM Sequencer

This block turns single-word read and write requests into the strobe sequence of a dynamic memory whose row and column addresses share one set of address pins. A requester holds `req_valid_i` with direction, address and write data until `req_ready_o` pulses. The upper bits of the request address select a row and the lower bits select a column. The row is placed on the bus with RAS falling. The column follows with CAS falling. CAS falling is the moment at which the memory performs the transfer.

After an access the row stays activated. A later request to the same row skips straight to the column phase. A request to another row first raises RAS for a precharge and then activates the new row. A timer asks for a refresh at a fixed interval. The refresh is served when no request hitting the open row is waiting. It closes any open row and strobes RAS alone on an internal row pointer, which advances after every refresh.

Top module: `dram_seq_ctrl`

## Requirements
- R1: After reset `mem_ras_no`, `mem_cas_no`, `mem_we_no` and `mem_oe_no` are all high and `req_ready_o` is low.
- R2: When RAS falls for an access, the bus carries the row, which is `req_addr_i[ROW_W+COL_W-1:COL_W]`. When CAS falls, the bus carries the column, which is `req_addr_i[COL_W-1:0]`. Both are zero-extended to the bus width.
- R3: `mem_we_no` is low for a write and high for a read. `mem_we_no` and `mem_addr_o` hold the same value in the cycle before CAS falls as in the cycle in which it falls.
- R4: `mem_cas_no` is low only while `mem_ras_no` is low.
- R5: A request whose row equals the row held open causes no RAS falling edge.
- R6: A request to a row that is not open causes at least one RAS falling edge. Every RAS falling edge is preceded by at least one clock with RAS high.
- R7: For a read, `req_rdata_o` is sampled from `mem_rdata_i` exactly CAS_LATENCY clocks after the clock edge at which CAS falls. It holds the data last written to that address. `req_ready_o` is high for that one cycle only.
- R8: For a write, `req_ready_o` pulses one clock after the edge at which CAS falls.
- R9: `mem_oe_no` goes low only during reads, and it is low at some point during every read.
- R10: A refresh is RAS low for exactly one clock with CAS high. Successive refreshes use rows that step by one, wrapping modulo 2^ROW_W.
- R11: While no request is pending, a refresh is made at least once in every REFRESH_INTERVAL clocks, closing any open row first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request pending; held until ready |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+COL_W | Full word address, row in upper bits |
| req_wdata_i | input | DATA_W | Write data |
| req_ready_o | output | 1 | One-cycle completion pulse |
| req_rdata_o | output | DATA_W | Read data, valid with ready |
| mem_addr_o | output | max(ROW_W,COL_W) | Shared row/column address bus |
| mem_ras_no | output | 1 | Row strobe, active low |
| mem_cas_no | output | 1 | Column strobe, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_wdata_o | output | DATA_W | Data to memory |
| mem_rdata_i | input | DATA_W | Data from memory |

## Verification
The bench builds the block with ROW_W = COL_W = 4, DATA_W = 8, a refresh interval of 40 clocks and a CAS latency of 3. The short interval makes refreshes collide with live traffic many times during a few hundred accesses. This covers refresh stealing an open row, a hit winning over a pending refresh, and wrap of the 16-entry refresh pointer. A latency above one makes the capture cycle distinguishable from the CAS edge. Drawing rows from only three values keeps row hits and misses both frequent.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACT,
    ST_CSET,
    ST_CAS,
    ST_DONE,
    ST_RACT,
    ST_REND
  } seq_state_e;
endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int INTERVAL = 390,
  parameter int ROW_W    = 4,
  localparam int CNT_W   = $clog2(INTERVAL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             served_i,
  output logic             pend_o,
  output logic [ROW_W-1:0] row_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;
  logic [ROW_W-1:0] row_q;
  logic             tick;

  assign tick = (cnt_q == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
      row_q  <= '0;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + 1'b1;
      if (tick)          pend_q <= 1'b1;
      else if (served_i) pend_q <= 1'b0;
      if (served_i)      row_q <= row_q + 1'b1;
    end
  end

  assign pend_o = pend_q;
  assign row_o  = row_q;

  // R10: a refresh is served only when one was requested
  p_serve_pending_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    served_i |-> pend_q);
endmodule

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int ROW_W   = 4,
  parameter int COL_W   = 4,
  parameter int BUS_W   = 4,
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ROW_W-1:0]  ref_row_i,
  output logic [ROW_W-1:0]  row_o,
  output logic [BUS_W-1:0]  row_bus_o,
  output logic [BUS_W-1:0]  col_bus_o,
  output logic [BUS_W-1:0]  ref_bus_o
);
  assign row_o     = addr_i[ADDR_W-1:COL_W];
  assign row_bus_o = BUS_W'(addr_i[ADDR_W-1:COL_W]);
  assign col_bus_o = BUS_W'(addr_i[COL_W-1:0]);
  assign ref_bus_o = BUS_W'(ref_row_i);
endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl #(
  parameter int ROW_W            = 4,
  parameter int COL_W            = 4,
  parameter int DATA_W           = 8,
  parameter int REFRESH_INTERVAL = 390,
  parameter int CAS_LATENCY      = 2,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W,
  localparam int LAT_W  = (CAS_LATENCY > 1) ? $clog2(CAS_LATENCY) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] req_rdata_o,
  output logic [BUS_W-1:0]  mem_addr_o,
  output logic              mem_ras_no,
  output logic              mem_cas_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import dram_seq_pkg::*;

  seq_state_e       state_q;
  logic [ROW_W-1:0] open_row_q, req_row, ref_row;
  logic             row_open_q, ref_pend, ref_served, hit;
  logic [BUS_W-1:0] row_bus, col_bus, ref_bus, addr_q;
  logic [LAT_W-1:0] lat_q;
  logic             ras_q, cas_q, we_q, oe_q, ready_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;

  dram_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W), .BUS_W(BUS_W)) u_split (
    .addr_i   (req_addr_i),
    .ref_row_i(ref_row),
    .row_o    (req_row),
    .row_bus_o(row_bus),
    .col_bus_o(col_bus),
    .ref_bus_o(ref_bus)
  );

  dram_ref_timer #(.INTERVAL(REFRESH_INTERVAL), .ROW_W(ROW_W)) u_ref (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .served_i(ref_served),
    .pend_o  (ref_pend),
    .row_o   (ref_row)
  );

  assign ref_served = (state_q == ST_REND);
  assign hit = req_valid_i && row_open_q && (req_row == open_row_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      open_row_q <= '0;
      row_open_q <= 1'b0;
      addr_q     <= '0;
      lat_q      <= '0;
      ras_q      <= 1'b1;
      cas_q      <= 1'b1;
      we_q       <= 1'b1;
      oe_q       <= 1'b1;
      ready_q    <= 1'b0;
      wdata_q    <= '0;
      rdata_q    <= '0;
    end else begin
      ready_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (hit) begin
            // open-row hit goes ahead of a pending refresh
            addr_q  <= col_bus;
            we_q    <= !req_we_i;
            oe_q    <= req_we_i;
            wdata_q <= req_wdata_i;
            state_q <= ST_CSET;
          end else if (ref_pend || req_valid_i) begin
            if (row_open_q) begin
              ras_q      <= 1'b1;
              row_open_q <= 1'b0;
              state_q    <= ST_PRE;
            end else if (ref_pend) begin
              addr_q  <= ref_bus;
              ras_q   <= 1'b0;
              state_q <= ST_RACT;
            end else begin
              addr_q     <= row_bus;
              ras_q      <= 1'b0;
              open_row_q <= req_row;
              row_open_q <= 1'b1;
              state_q    <= ST_ACT;
            end
          end
        end
        ST_PRE:  state_q <= ST_IDLE;
        ST_ACT: begin
          addr_q  <= col_bus;
          we_q    <= !req_we_i;
          oe_q    <= req_we_i;
          wdata_q <= req_wdata_i;
          state_q <= ST_CSET;
        end
        ST_CSET: begin
          cas_q   <= 1'b0;
          lat_q   <= LAT_W'(CAS_LATENCY - 1);
          state_q <= ST_CAS;
        end
        ST_CAS: begin
          if (!we_q) begin
            cas_q   <= 1'b1;
            we_q    <= 1'b1;
            ready_q <= 1'b1;
            state_q <= ST_DONE;
          end else if (lat_q == '0) begin
            rdata_q <= mem_rdata_i;
            cas_q   <= 1'b1;
            oe_q    <= 1'b1;
            ready_q <= 1'b1;
            state_q <= ST_DONE;
          end else begin
            lat_q <= lat_q - 1'b1;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        ST_RACT: begin
          ras_q   <= 1'b1;
          state_q <= ST_REND;
        end
        ST_REND: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_ras_no  = ras_q;
  assign mem_cas_no  = cas_q;
  assign mem_we_no   = we_q;
  assign mem_oe_no   = oe_q;
  assign mem_wdata_o = wdata_q;
  assign req_ready_o = ready_q;
  assign req_rdata_o = rdata_q;

  p_cas_in_row_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_q |-> !ras_q);

  p_we_setup_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cas_q) |-> ($stable(we_q) && $stable(addr_q)));

  p_oe_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_q |-> (we_q && !ras_q));

  p_ready_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_q |=> !ready_q);

  p_precharge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ras_q) |-> $past(state_q) != ST_CAS);
endmodule

// File: tb/dram_seq_ctrl_tb_top.sv
module dram_seq_ctrl_tb_top;
  localparam int ROW_W = 4;
  localparam int COL_W = 4;
  localparam int DW    = 8;
  localparam int RI    = 40;
  localparam int CL    = 3;
  localparam int AW    = ROW_W + COL_W;
  localparam int BW    = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready;
  logic [DW-1:0] req_rdata;
  logic [BW-1:0] mem_addr;
  logic ras_n, cas_n, we_n, oe_n;
  logic [DW-1:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  dram_seq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW),
                  .REFRESH_INTERVAL(RI), .CAS_LATENCY(CL)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .req_ready_o(req_ready), .req_rdata_o(req_rdata),
    .mem_addr_o(mem_addr), .mem_ras_no(ras_n), .mem_cas_no(cas_n),
    .mem_we_no(we_n), .mem_oe_no(oe_n), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata)
  );

  // memory model
  logic [DW-1:0] marr [2**AW];
  logic [ROW_W-1:0] m_row;
  logic m_pras, m_pcas;
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < 2**AW; i++) marr[i] <= '0;
      m_row <= '0; m_pras <= 1'b1; m_pcas <= 1'b1;
    end else begin
      m_pras <= ras_n; m_pcas <= cas_n;
      if (m_pras && !ras_n) m_row <= mem_addr[ROW_W-1:0];
      if (m_pcas && !cas_n && !we_n) marr[{m_row, mem_addr[COL_W-1:0]}] <= mem_wdata;
    end
  end
  assign mem_rdata = (!oe_n && !cas_n) ? marr[{m_row, mem_addr[COL_W-1:0]}] : '0;

  int n_chk = 0, n_fail = 0;
  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // pin monitor
  int cyc = 0, ras_falls = 0, ref_cnt = 0, ras_lo = 0, ras_hi = 1;
  int cas_cyc = 0, rdy_cyc = 0, v_pre = 0, v_cas = 0, v_oe = 0, v_setup = 0, v_ref = 0;
  logic p_ras = 1, p_cas = 1, p_we = 1, act_open = 0, have_ref = 0, oe_seen = 0, cas_we = 1;
  logic [BW-1:0] p_addr = '0;
  logic [ROW_W-1:0] fall_row = '0, open_row = '0, last_ref = '0, cas_row = '0;
  logic [COL_W-1:0] cas_col = '0;
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (p_ras && !ras_n) begin
        ras_falls++;
        if (ras_hi < 1) v_pre++;
        fall_row = mem_addr[ROW_W-1:0];
        act_open = 0; ras_lo = 0;
      end
      if (!p_ras && ras_n) begin
        if (!act_open) begin
          ref_cnt++;
          if (have_ref && fall_row != ROW_W'(last_ref + 1)) v_ref++;
          if (ras_lo != 1) v_ref++;
          last_ref = fall_row; have_ref = 1;
        end
        act_open = 0; ras_hi = 0;
      end
      if (p_cas && !cas_n) begin
        cas_cyc = cyc; cas_row = fall_row; cas_col = mem_addr[COL_W-1:0];
        cas_we = we_n; act_open = 1; open_row = fall_row;
        if (p_we != we_n || p_addr != mem_addr) v_setup++;
      end
      if (!cas_n && ras_n) v_cas++;
      if (!oe_n && !we_n) v_oe++;
      if (!oe_n) oe_seen = 1;
      if (req_ready) rdy_cyc = cyc;
      if (!ras_n) ras_lo++; else ras_hi++;
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = mem_addr;
  end

  logic [DW-1:0] shadow [2**AW];

  task automatic access(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [ROW_W-1:0] r;
    bit exp_hit, done;
    int f0;
    r = a[AW-1:COL_W];
    @(negedge clk); #1;
    exp_hit = act_open && !ras_n && (open_row == r);
    f0 = ras_falls; oe_seen = 0;
    req_valid = 1; req_we = wr; req_addr = a; req_wdata = d;
    done = 0;
    for (int t = 0; t < 300 && !done; t++) begin
      @(negedge clk); #1;
      if (req_ready) done = 1;
    end
    chk(done, "R7 ready seen", {31'b0, done}, 1);
    req_valid = 0;
    chk(cas_row == r && cas_col == a[COL_W-1:0], "R2 row/col at strobes",
        {cas_row, cas_col}, a);
    chk(cas_we == !wr, "R3 we level at CAS", cas_we, !wr);
    if (exp_hit) chk(ras_falls == f0, "R5 no RAS on hit", ras_falls - f0, 0);
    else         chk(ras_falls > f0, "R6 RAS on miss", ras_falls - f0, 1);
    if (wr) begin
      chk(rdy_cyc - cas_cyc == 1, "R8 write ready delay", rdy_cyc - cas_cyc, 1);
      shadow[a] = d;
    end else begin
      chk(rdy_cyc - cas_cyc == CL, "R7 read latency", rdy_cyc - cas_cyc, CL);
      chk(req_rdata == shadow[a], "R7 read data", req_rdata, shadow[a]);
      chk(oe_seen, "R9 oe during read", {31'b0, oe_seen}, 1);
    end
    @(negedge clk); #1;
    chk(!req_ready, "R7 ready one cycle", {31'b0, req_ready}, 0);
  endtask

  bit fin = 0;
  task automatic finish_run();
    if (!fin) begin
      fin = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int r0;
    for (int i = 0; i < 2**AW; i++) shadow[i] = '0;
    void'($urandom(32'd2270));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ras_n && cas_n && we_n && oe_n && !req_ready, "R1 reset strobes",
        {ras_n, cas_n, we_n, oe_n, req_ready}, 5'b11110);
    rst_ni = 1;
    // directed: miss write, hit read, back-to-back hits, miss to other row
    access(1, 8'h35, 8'hA7);
    access(0, 8'h35, 8'h00);
    access(1, 8'h3F, 8'h5C);
    access(1, 8'h30, 8'hC3);
    access(0, 8'h3F, 8'h00);
    access(0, 8'h90, 8'h00);
    access(0, 8'h30, 8'h00);
    // R11 idle refresh
    r0 = ref_cnt;
    repeat (5 * RI) @(negedge clk);
    #1;
    chk(ref_cnt - r0 >= 4, "R11 idle refresh count", ref_cnt - r0, 4);
    chk(!act_open, "R11 open row closed by refresh", {31'b0, act_open}, 0);
    // random traffic over few rows
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      a = {ROW_W'($urandom % 3), COL_W'($urandom)};
      access(bit'($urandom % 2), a, DW'($urandom));
      repeat ($urandom % 6) @(negedge clk);
    end
    repeat (3 * RI) @(negedge clk);
    #1;
    chk(ref_cnt >= 16, "R10 refresh pointer wrap reached", ref_cnt, 16);
    chk(v_ref == 0, "R10 refresh row step and width", v_ref, 0);
    chk(v_cas == 0, "R4 CAS only within RAS", v_cas, 0);
    chk(v_pre == 0, "R6 precharge before RAS fall", v_pre, 0);
    chk(v_oe == 0, "R9 OE only on reads", v_oe, 0);
    chk(v_setup == 0, "R3 WE/addr setup before CAS", v_setup, 0);
    finish_run();
  end
endmodule